// File: doc/BRIEF.md
# Four-Source Latched Interrupt Controller

This block collects interrupt events from four sources and holds each one in a sticky latch until software clears it. The four sources are a timer with a selectable rate, a once-per-second tick, and two external request pins, one from the video side and one from the network side. The timer's event comes from one of four one-cycle strobes, picked by a 2-bit rate code: a 1 kHz tick, a 50 Hz tick, or the pulse output of either of two tone generators.

Software controls the block through one 8-bit location. A write gives every source a pair of bits, one that enables it and one that clears its latch. A read returns, for every source, the latch state and the state of a toggle flip-flop that flips on each event of that source. This lets code poll for pending events even when the processor has interrupts masked. The request line is open-drain: it pulls low whenever any latch is set. It is modelled as an active-low level plus a drive-enable.

The external pins are asynchronous and active on their falling edges. They pass through a synchronizer before edge detection. The asynchronous reset is released into the logic through a two-stage synchronizer.

Top module: `irqc_four_src`

## Requirements
- R1: While reset is asserted, `status_rdata` reads 8'h00, `irq_n` is 1 and `irq_oe` is 0. The internal logic leaves reset two clock edges after `rst_n` rises.
- R2: The timer source (index 0) takes its event from `rate_sel`: 2'b00 uses `tick_1khz`, 2'b01 uses `tick_50hz`, 2'b10 uses `tone0_pulse`, and 2'b11 uses `tone1_pulse`. Strobes that are not selected have no effect.
- R3: Sources are indexed timer=0, one-second=1, video=2, network=3. In `status_rdata`, bit 2*i holds the toggle of source i and bit 2*i+1 holds its latch. The toggle inverts on every event of its source, whether or not the source is enabled.
- R4: A latch sets on a source event only if that source's enable bit was already 1 before the clock edge. A set latch stays set until it is cleared.
- R5: A write with `ctrl_we`=1 loads enable i from `ctrl_wdata[2*i]`. If `ctrl_wdata[2*i+1]` is 1, the write clears latch i at that edge. A clear wins over an event in the same cycle.
- R6: `video_irq_n` and `net_irq_n` act only on falling edges. A low level first sampled at clock edge k sets the latch and flips the toggle at edge k+2. A level held low, or a rising edge, causes no further event.
- R7: `irq_n` is 0 and `irq_oe` is 1 exactly while at least one latch is set. Otherwise `irq_n` is 1 and `irq_oe` is 0.
- R8: Writing 8'h00 disables all four sources. Later events still flip the toggles, but they set no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Timer rate code |
| tick_1khz | input | 1 | One-cycle strobe at 1 kHz |
| tick_50hz | input | 1 | One-cycle strobe at 50 Hz |
| tick_1hz | input | 1 | One-cycle strobe at 1 Hz |
| tone0_pulse | input | 1 | Event strobe from tone generator 0 |
| tone1_pulse | input | 1 | Event strobe from tone generator 1 |
| video_irq_n | input | 1 | Asynchronous video request, falling-edge active |
| net_irq_n | input | 1 | Asynchronous network request, falling-edge active |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Enable/clear bit pairs |
| status_rdata | output | 8 | Toggle/latch bit pairs |
| irq_n | output | 1 | Request level, active low |
| irq_oe | output | 1 | Drive enable for the open-drain request |

## Verification
The bench targets five corner cases, and each has a distinct failure signature:
- **Clear and event in the same cycle.** A design that gives the event priority would leave the request asserted after software has acknowledged it.
- **Strobes off the selected timer rate.** A mux error would set the timer latch from the wrong strobe.
- **Events on a disabled source.** These must still flip the toggle without latching. A design that gates the toggle with the enable would freeze the read-back square wave. One that ignores the enable would raise requests after a write of zero.
- **External pins held low, then released.** These catch a level-sensitive detector, which would retrigger immediately after a clear. They also catch a detector that fires on the rising edge.
- **Synchronizer latency.** The exact delay is checked, so a design with one register too many or too few fails.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_EXT  = 2;
  localparam int NUM_SRC  = 2 + NUM_EXT;
  localparam int CTRL_W   = 2 * NUM_SRC;
  localparam int SRC_TMR  = 0;
  localparam int SRC_SEC  = 1;
  localparam int SRC_EXT0 = 2;

  typedef enum logic [1:0] {
    RATE_1K    = 2'b00,
    RATE_50    = 2'b01,
    RATE_TONE0 = 2'b10,
    RATE_TONE1 = 2'b11
  } rate_sel_e;
endpackage

// File: rtl/irqc_fall_det.sv
module irqc_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              dly_q, dly_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_n};
    dly_d   = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      dly_q   <= 1'b1;
    end else begin
      chain_q <= chain_d;
      dly_q   <= dly_d;
    end
  end

  assign fall_o = dly_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/irqc_rate_mux.sv
module irqc_rate_mux
  import irqc_pkg::*;
(
  input  logic [1:0] rate_sel,
  input  logic       tick_1khz,
  input  logic       tick_50hz,
  input  logic       tone0_pulse,
  input  logic       tone1_pulse,
  output logic       tmr_evt
);
  always_comb begin
    unique case (rate_sel_e'(rate_sel))
      RATE_1K:    tmr_evt = tick_1khz;
      RATE_50:    tmr_evt = tick_50hz;
      RATE_TONE0: tmr_evt = tone0_pulse;
      RATE_TONE1: tmr_evt = tone1_pulse;
      default:    tmr_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic en_i,
  input  logic clr_i,
  output logic div_o,
  output logic lat_o
);
  logic div_q, div_d;
  logic lat_q, lat_d;
  logic lat_ce;

  always_comb begin
    div_d  = ~div_q;
    lat_ce = clr_i | (evt_i & en_i);
    lat_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      if (evt_i)  div_q <= div_d;
      if (lat_ce) lat_q <= lat_d;
    end
  end

  assign div_o = div_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/irqc_four_src.sv
module irqc_four_src
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              tick_1khz,
  input  logic              tick_50hz,
  input  logic              tick_1hz,
  input  logic              tone0_pulse,
  input  logic              tone1_pulse,
  input  logic              video_irq_n,
  input  logic              net_irq_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] status_rdata,
  output logic              irq_n,
  output logic              irq_oe
);
  logic [1:0]         rst_pipe_q;
  logic               core_rst_n;
  logic [NUM_SRC-1:0] en_q, en_d, en_wr, clr, src_evt, div, lat;
  logic [NUM_EXT-1:0] ext_n;
  logic               any_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  irqc_rate_mux u_rate (
    .rate_sel    (rate_sel),
    .tick_1khz   (tick_1khz),
    .tick_50hz   (tick_50hz),
    .tone0_pulse (tone0_pulse),
    .tone1_pulse (tone1_pulse),
    .tmr_evt     (src_evt[SRC_TMR])
  );
  assign src_evt[SRC_SEC] = tick_1hz;

  assign ext_n = {net_irq_n, video_irq_n};
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    irqc_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .pin_n  (ext_n[g]),
      .fall_o (src_evt[SRC_EXT0+g])
    );
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign en_wr[i] = ctrl_wdata[2*i];
    assign clr[i]   = ctrl_we & ctrl_wdata[2*i+1];

    irqc_src_cell u_cell (
      .clk   (clk),
      .rst_n (core_rst_n),
      .evt_i (src_evt[i]),
      .en_i  (en_q[i]),
      .clr_i (clr[i]),
      .div_o (div[i]),
      .lat_o (lat[i])
    );

    assign status_rdata[2*i]   = div[i];
    assign status_rdata[2*i+1] = lat[i];
  end

  always_comb en_d = en_wr;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  en_q <= '0;
    else if (ctrl_we) en_q <= en_d;
  end

  assign any_lat = |lat;
  assign irq_n   = ~any_lat;
  assign irq_oe  = any_lat;
endmodule

// File: rtl/irqc_four_src_chk.sv
module irqc_four_src_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rate_sel,
  input logic       tick_1khz,
  input logic       tick_50hz,
  input logic       tick_1hz,
  input logic       tone0_pulse,
  input logic       tone1_pulse,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic [7:0] status_rdata,
  input logic       irq_n,
  input logic       irq_oe,
  input logic [3:0] en_q
);
  logic sel_tick;
  logic any_lat;
  assign sel_tick = (rate_sel == 2'b00) ? tick_1khz :
                    (rate_sel == 2'b01) ? tick_50hz :
                    (rate_sel == 2'b10) ? tone0_pulse : tone1_pulse;
  assign any_lat = status_rdata[1] | status_rdata[3] | status_rdata[5] | status_rdata[7];

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (status_rdata == 8'h00 && irq_n && !irq_oe))
    else $error("reset state violated");

  p_tmr_toggle_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_rdata[0]) |-> $past(sel_tick))
    else $error("timer toggle moved without selected strobe");

  p_sec_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_rdata[2]) |-> $past(tick_1hz))
    else $error("second toggle moved without tick");

  for (genvar i = 0; i < 4; i++) begin : g_src
    p_set_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_rdata[2*i+1]) |-> $past(en_q[i]))
      else $error("latch set while disabled");

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && ctrl_wdata[2*i+1]) |=> !status_rdata[2*i+1])
      else $error("clear did not take effect");
  end

  p_request_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n == !any_lat) && (irq_oe == any_lat))
    else $error("request line disagrees with latches");
endmodule

bind irqc_four_src irqc_four_src_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rate_sel     (rate_sel),
  .tick_1khz    (tick_1khz),
  .tick_50hz    (tick_50hz),
  .tick_1hz     (tick_1hz),
  .tone0_pulse  (tone0_pulse),
  .tone1_pulse  (tone1_pulse),
  .ctrl_we      (ctrl_we),
  .ctrl_wdata   (ctrl_wdata),
  .status_rdata (status_rdata),
  .irq_n        (irq_n),
  .irq_oe       (irq_oe),
  .en_q         (en_q)
);

// File: tb/irqc_four_src_bench.sv
module irqc_four_src_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate_sel;
  logic       tick_1khz, tick_50hz, tick_1hz, tone0_pulse, tone1_pulse;
  logic       video_irq_n, net_irq_n;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata;
  logic [7:0] status_rdata;
  logic       irq_n, irq_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  logic [3:0] m_en, m_div, m_lat;
  logic [2:0] m_vp, m_np;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_four_src u_irqc_four_src (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .tick_1khz(tick_1khz), .tick_50hz(tick_50hz), .tick_1hz(tick_1hz),
    .tone0_pulse(tone0_pulse), .tone1_pulse(tone1_pulse),
    .video_irq_n(video_irq_n), .net_irq_n(net_irq_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .status_rdata(status_rdata), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    for (int i = 0; i < 4; i++) begin
      s[2*i]   = m_div[i];
      s[2*i+1] = m_lat[i];
    end
    return s;
  endfunction

  function automatic logic sel_evt(logic [1:0] sel, logic k1, logic k50, logic t0, logic t1);
    case (sel)
      2'b00:   return k1;
      2'b01:   return k50;
      2'b10:   return t0;
      default: return t1;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    tick_1khz = 0; tick_50hz = 0; tick_1hz = 0;
    tone0_pulse = 0; tone1_pulse = 0; ctrl_we = 0; ctrl_wdata = 8'h00;
  endtask

  task automatic tick();
    logic [3:0] ev;
    logic [3:0] nlat;
    ev[0] = sel_evt(rate_sel, tick_1khz, tick_50hz, tone0_pulse, tone1_pulse);
    ev[1] = tick_1hz;
    ev[2] = !m_vp[1] && m_vp[2];
    ev[3] = !m_np[1] && m_np[2];
    for (int i = 0; i < 4; i++)
      nlat[i] = (ctrl_we && ctrl_wdata[2*i+1]) ? 1'b0 : (m_lat[i] | (ev[i] & m_en[i]));
    @(posedge clk);
    m_div = m_div ^ ev;
    m_lat = nlat;
    if (ctrl_we)
      for (int i = 0; i < 4; i++) m_en[i] = ctrl_wdata[2*i];
    m_vp = {m_vp[1:0], video_irq_n};
    m_np = {m_np[1:0], net_irq_n};
    @(negedge clk);
    chk("R2/R3/R4/R5/R6", status_rdata, exp_status());
    chk("R7 irq_n", {7'd0, irq_n}, {7'd0, ~(|m_lat)});
    chk("R7 irq_oe", {7'd0, irq_oe}, {7'd0, |m_lat});
    clear_strobes();
  endtask

  task automatic wr(logic [7:0] d);
    ctrl_we = 1; ctrl_wdata = d;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_strobes();
    rate_sel = 2'b00; video_irq_n = 1; net_irq_n = 1;
    rst_n = 1;
    #1 rst_n = 0;
    m_en = 0; m_div = 0; m_lat = 0; m_vp = 3'b111; m_np = 3'b111;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 status", status_rdata, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 irq_oe", {7'd0, irq_oe}, 8'h00);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: 50 Hz selected, 1 kHz strobe ignored
    rate_sel = 2'b01;
    wr(8'h01);
    tick_1khz = 1; tick();
    chk("R2 unselected strobe", status_rdata, 8'h00);
    tick_50hz = 1; tick();
    chk("R2 selected strobe", status_rdata, 8'h03);
    chk("R7 asserted", {7'd0, irq_n}, 8'h00);
    // R5: clear wins over simultaneous event
    tick_50hz = 1; wr(8'h03);
    chk("R5 clear wins", status_rdata, 8'h00);
    // R2 tone sources, R4 disabled source
    rate_sel = 2'b10; tone0_pulse = 1; tick();
    chk("R2 tone0", status_rdata, 8'h03);
    wr(8'h02);
    chk("R5 clear", status_rdata, 8'h01);
    rate_sel = 2'b11; tone1_pulse = 1; tick();
    chk("R4 disabled no latch", status_rdata, 8'h00);

    // R6: falling edge with synchronizer latency
    wr(8'h10);
    video_irq_n = 0;
    tick(); tick();
    chk("R6 not yet", status_rdata, 8'h00);
    tick();
    chk("R6 edge latched", status_rdata, 8'h30);
    repeat (4) tick();
    chk("R6 level no retrigger", status_rdata, 8'h30);
    wr(8'h20);
    chk("R6 cleared", status_rdata, 8'h10);
    video_irq_n = 1;
    repeat (4) tick();
    chk("R6 rising ignored", status_rdata, 8'h10);

    // R8: zero write disables all
    wr(8'h55);
    wr(8'h00);
    tick_1hz = 1; tick();
    chk("R8 sec toggles no latch", status_rdata, 8'h14);
    net_irq_n = 0;
    repeat (3) tick();
    chk("R8 net toggles no latch", status_rdata, 8'h54);
    chk("R8 no request", {7'd0, irq_n}, 8'h01);

    // Random phase, checked against the model each cycle
    for (int c = 0; c < 4000; c++) begin
      tick_1khz   = ($urandom_range(0, 5) == 0);
      tick_50hz   = ($urandom_range(0, 5) == 0);
      tick_1hz    = ($urandom_range(0, 7) == 0);
      tone0_pulse = ($urandom_range(0, 4) == 0);
      tone1_pulse = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 15) == 0) rate_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) video_irq_n = ~video_irq_n;
      if ($urandom_range(0, 4) == 0) net_irq_n = ~net_irq_n;
      if ($urandom_range(0, 5) == 0) begin
        ctrl_we = 1;
        ctrl_wdata = 8'($urandom);
      end
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule